// File: doc/BRIEF.md
# Flagless 32-bit Execution Unit with Compare, Shift and Rotate

This block is the integer execution stage of a small RISC core that keeps no condition flags. Each operation takes operand A from the register file, and operand B either from the register file or from a 16-bit immediate taken out of the instruction word. The operation chosen sets how that immediate is widened: sign extension, zero extension, or placement in the upper half of the word. The unit covers addition, subtraction, the four bitwise operations (including NOR), the compare-and-set family, logical and arithmetic shifts, and rotates in both directions.

Addition and subtraction wrap modulo 2^32 and report nothing else, so one adder serves signed and unsigned data alike. A comparison does not set a flag. It writes a whole result word holding 1 when the relation is true and 0 when it is false. Software builds carry and overflow tests from these compares.

The result is computed combinationally and captured in an output register on the clock edge at which `start` is high. `result_valid` is high for the one cycle that follows each start cycle. The register keeps its value until the next start.

Top module: `flagless_alu`

## Requirements
- R1: Operation code 0 adds A and B, and code 1 subtracts B from A. Both wrap modulo 2^32 and use the same adder for signed and unsigned data.
- R2: When `imm_sel` is 1, the extended immediate replaces operand B. The immediate is sign-extended for codes 0, 1, 9, 10, 11 and 12. It is zero-extended for codes 2 to 5 and 13 to 19.
- R3: Codes 6, 7 and 8 perform AND, OR and XOR. With `imm_sel` set, they place the immediate in bits 31:16 and zeros in bits 15:0, so bits 15:0 of A pass through an OR or an XOR unchanged.
- R4: Codes 2, 3, 4 and 5 perform bitwise AND, OR, XOR and NOR of A and B.
- R5: Codes 9 to 14 compare A with B: equal, not equal, signed less than, signed greater-or-equal, unsigned less than, unsigned greater-or-equal. The result is 32'd1 when the relation holds and 32'd0 when it does not.
- R6: Shift and rotate amounts come only from bits 4:0 of operand B. Bits 31:5 of B are ignored.
- R7: Code 15 shifts left and fills the vacated bits with zeros. Code 16 shifts right and fills with zeros. Code 17 shifts right and fills with copies of bit 31 of A.
- R8: Code 18 rotates A left and code 19 rotates A right. Both work with a register amount and with an immediate amount.
- R9: For every shift and rotate, an amount of zero returns A unchanged.
- R10: `result` takes the new value on the clock edge at which `start` is high, and `result_valid` is high for exactly the one cycle after each start cycle. Without `start`, `result` keeps its value.
- R11: After reset, `result` is 0 and `result_valid` is 0.
- R12: Codes 20 to 31 are unused and produce a result of 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Capture the result of the present inputs |
| op | input | 5 | Operation code |
| imm_sel | input | 1 | 1: operand B is the extended immediate |
| src_a | input | 32 | Operand A |
| src_b | input | 32 | Register operand B |
| imm | input | 16 | Immediate field |
| result | output | 32 | Registered result |
| result_valid | output | 1 | High for the cycle after each start |

## Verification
Every fault shows up at `result` exactly one cycle after the start that used the faulty path, because the unit holds no state other than the output register. The notable exceptions are faults in the valid timing, which show up as a missing pulse or a pulse that stays high one cycle too long. A wrong extension mode shows only when the immediate has bit 15 set. A wrong barrel stage shows only for amounts that use that stage. For this reason the directed tests use negative immediates and amounts that reach each of the five stages.

// File: rtl/alu_pkg.sv
package alu_pkg;

  localparam int OP_W = 5;

  typedef enum logic [OP_W-1:0] {
    OP_ADD  = 5'd0,
    OP_SUB  = 5'd1,
    OP_AND  = 5'd2,
    OP_OR   = 5'd3,
    OP_XOR  = 5'd4,
    OP_NOR  = 5'd5,
    OP_ANDH = 5'd6,
    OP_ORH  = 5'd7,
    OP_XORH = 5'd8,
    OP_CEQ  = 5'd9,
    OP_CNE  = 5'd10,
    OP_CLT  = 5'd11,
    OP_CGE  = 5'd12,
    OP_CLTU = 5'd13,
    OP_CGEU = 5'd14,
    OP_SLL  = 5'd15,
    OP_SRL  = 5'd16,
    OP_SRA  = 5'd17,
    OP_ROL  = 5'd18,
    OP_ROR  = 5'd19
  } alu_op_e;

  typedef enum logic [1:0] {
    EXT_SIGN = 2'd0,
    EXT_ZERO = 2'd1,
    EXT_HIGH = 2'd2
  } ext_mode_e;

  typedef enum logic [1:0] {
    GRP_ARITH = 2'd0,
    GRP_CMP   = 2'd1,
    GRP_SHIFT = 2'd2,
    GRP_NONE  = 2'd3
  } op_group_e;

  function automatic ext_mode_e ext_mode_of(input alu_op_e op);
    case (op)
      OP_ADD, OP_SUB, OP_CEQ, OP_CNE, OP_CLT, OP_CGE: ext_mode_of = EXT_SIGN;
      OP_ANDH, OP_ORH, OP_XORH:                       ext_mode_of = EXT_HIGH;
      default:                                        ext_mode_of = EXT_ZERO;
    endcase
  endfunction

  function automatic op_group_e group_of(input alu_op_e op);
    case (op)
      OP_ADD, OP_SUB, OP_AND, OP_OR, OP_XOR, OP_NOR,
      OP_ANDH, OP_ORH, OP_XORH:                         group_of = GRP_ARITH;
      OP_CEQ, OP_CNE, OP_CLT, OP_CGE, OP_CLTU, OP_CGEU: group_of = GRP_CMP;
      OP_SLL, OP_SRL, OP_SRA, OP_ROL, OP_ROR:           group_of = GRP_SHIFT;
      default:                                          group_of = GRP_NONE;
    endcase
  endfunction

endpackage

// File: rtl/alu_opnd_sel.sv
module alu_opnd_sel
  import alu_pkg::*;
#(
  parameter int WIDTH = 32,
  parameter int IMM_W = 16
) (
  input  alu_op_e          op,
  input  logic             imm_sel,
  input  logic [WIDTH-1:0] src_b,
  input  logic [IMM_W-1:0] imm,
  output logic [WIDTH-1:0] opnd_b,
  output ext_mode_e        ext_mode
);

  localparam int PAD_W = WIDTH - IMM_W;

  function automatic logic [WIDTH-1:0] widen(input logic [IMM_W-1:0] v,
                                             input ext_mode_e m);
    case (m)
      EXT_SIGN: widen = {{PAD_W{v[IMM_W-1]}}, v};
      EXT_HIGH: widen = {v, {PAD_W{1'b0}}};
      default:  widen = {{PAD_W{1'b0}}, v};
    endcase
  endfunction

  assign ext_mode = ext_mode_of(op);
  assign opnd_b   = imm_sel ? widen(imm, ext_mode) : src_b;

endmodule

// File: rtl/alu_arith_logic.sv
module alu_arith_logic
  import alu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  alu_op_e          op,
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  output logic [WIDTH-1:0] out
);

  function automatic logic [WIDTH-1:0] add_sub(input logic [WIDTH-1:0] x,
                                               input logic [WIDTH-1:0] y,
                                               input logic             minus);
    logic [WIDTH-1:0] yy;
    yy = minus ? ~y : y;
    add_sub = x + yy + {{(WIDTH-1){1'b0}}, minus};
  endfunction

  logic [WIDTH-1:0] sum;
  assign sum = add_sub(a, b, op == OP_SUB);

  always_comb begin
    case (op)
      OP_ADD, OP_SUB:   out = sum;
      OP_AND, OP_ANDH:  out = a & b;
      OP_OR,  OP_ORH:   out = a | b;
      OP_XOR, OP_XORH:  out = a ^ b;
      OP_NOR:           out = ~(a | b);
      default:          out = '0;
    endcase
  end

endmodule

// File: rtl/alu_cmp.sv
module alu_cmp
  import alu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  alu_op_e          op,
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  output logic             cmp_true
);

  logic eq_w, ne_w, lt_s_w, ge_s_w, lt_u_w, ge_u_w;

  function automatic logic signed_less(input logic [WIDTH-1:0] x,
                                       input logic [WIDTH-1:0] y);
    if (x[WIDTH-1] != y[WIDTH-1]) signed_less = x[WIDTH-1];
    else                          signed_less = x < y;
  endfunction

  assign eq_w   = (a == b);
  assign ne_w   = |(a ^ b);
  assign lt_s_w = signed_less(a, b);
  assign ge_s_w = $signed(a) >= $signed(b);
  assign lt_u_w = a < b;
  assign ge_u_w = a >= b;

  always_comb begin
    case (op)
      OP_CEQ:  cmp_true = eq_w;
      OP_CNE:  cmp_true = ne_w;
      OP_CLT:  cmp_true = lt_s_w;
      OP_CGE:  cmp_true = ge_s_w;
      OP_CLTU: cmp_true = lt_u_w;
      OP_CGEU: cmp_true = ge_u_w;
      default: cmp_true = 1'b0;
    endcase
  end

  // R5
  cmp_signed_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lt_s_w ^ ge_s_w);
  // R5
  cmp_unsigned_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lt_u_w ^ ge_u_w);
  // R5
  cmp_eq_ne_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eq_w ^ ne_w);
  // R5
  cmp_eq_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eq_w |-> (!lt_s_w && !lt_u_w));

endmodule

// File: rtl/alu_shrot.sv
module alu_shrot
  import alu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  alu_op_e          op,
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  output logic [WIDTH-1:0] out
);

  localparam int SHW = $clog2(WIDTH);

  function automatic logic [WIDTH-1:0] bit_rev(input logic [WIDTH-1:0] v);
    for (int i = 0; i < WIDTH; i++) bit_rev[i] = v[WIDTH-1-i];
  endfunction

  logic [SHW-1:0]   amt;
  logic             go_left;
  logic             wrap;
  logic             fill_bit;
  logic [WIDTH-1:0] stg [0:SHW];

  assign amt      = b[SHW-1:0];
  assign go_left  = (op == OP_SLL) || (op == OP_ROL);
  assign wrap     = (op == OP_ROL) || (op == OP_ROR);
  assign fill_bit = (op == OP_SRA) ? a[WIDTH-1] : 1'b0;
  assign stg[0]   = go_left ? bit_rev(a) : a;

  for (genvar k = 0; k < SHW; k++) begin : g_stage
    localparam int S = 1 << k;
    logic [S-1:0] fill;
    assign fill       = wrap ? stg[k][S-1:0] : {S{fill_bit}};
    assign stg[k+1]   = amt[k] ? {fill, stg[k][WIDTH-1:S]} : stg[k];
  end

  assign out = go_left ? bit_rev(stg[SHW]) : stg[SHW];

  // R9
  zero_amount_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (amt == '0) |-> (out == a));
  // R7
  sra_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_SRA) |-> (out[WIDTH-1] == a[WIDTH-1]));
  // R7
  sll_lsb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_SLL && amt != '0) |-> !out[0]);
  // R8
  rot_popcount_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_ROL || op == OP_ROR) |-> ($countones(out) == $countones(a)));

endmodule

// File: rtl/flagless_alu.sv
module flagless_alu
  import alu_pkg::*;
#(
  parameter int WIDTH = 32,
  parameter int IMM_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [4:0]       op,
  input  logic             imm_sel,
  input  logic [WIDTH-1:0] src_a,
  input  logic [WIDTH-1:0] src_b,
  input  logic [IMM_W-1:0] imm,
  output logic [WIDTH-1:0] result,
  output logic             result_valid
);

  localparam int LOW_W = WIDTH - IMM_W;

  alu_op_e          op_e;
  ext_mode_e        ext_mode;
  op_group_e        grp;
  logic [WIDTH-1:0] opnd_b;
  logic [WIDTH-1:0] al_out;
  logic [WIDTH-1:0] sh_out;
  logic             cmp_true;
  logic [WIDTH-1:0] next_result;
  logic [WIDTH-1:0] result_q;
  logic             valid_q;

  assign op_e = alu_op_e'(op);
  assign grp  = group_of(op_e);

  alu_opnd_sel #(.WIDTH(WIDTH), .IMM_W(IMM_W)) u_opnd (
    .op(op_e), .imm_sel(imm_sel), .src_b(src_b), .imm(imm),
    .opnd_b(opnd_b), .ext_mode(ext_mode)
  );

  alu_arith_logic #(.WIDTH(WIDTH)) u_al (
    .op(op_e), .a(src_a), .b(opnd_b), .out(al_out)
  );

  alu_cmp #(.WIDTH(WIDTH)) u_cmp (
    .clk(clk), .rst_n(rst_n), .op(op_e), .a(src_a), .b(opnd_b),
    .cmp_true(cmp_true)
  );

  alu_shrot #(.WIDTH(WIDTH)) u_sh (
    .clk(clk), .rst_n(rst_n), .op(op_e), .a(src_a), .b(opnd_b),
    .out(sh_out)
  );

  always_comb begin
    case (grp)
      GRP_ARITH: next_result = al_out;
      GRP_CMP:   next_result = {{(WIDTH-1){1'b0}}, cmp_true};
      GRP_SHIFT: next_result = sh_out;
      default:   next_result = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      result_q <= '0;
      valid_q  <= 1'b0;
    end else begin
      valid_q <= start;
      if (start) result_q <= next_result;
    end
  end

  assign result       = result_q;
  assign result_valid = valid_q;

  // R10
  valid_follows_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> result_valid);
  // R10
  valid_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> !result_valid);
  // R10
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> $stable(result));
  // R3
  high_low_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && imm_sel && op_e == OP_ORH) |=> (result[LOW_W-1:0] == $past(src_a[LOW_W-1:0])));
  // R12
  unused_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && grp == GRP_NONE) |=> (result == '0));
  // R5
  cmp_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && grp == GRP_CMP) |=> (result[WIDTH-1:1] == '0));
  // R2
  sign_ext_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && imm_sel && ext_mode == EXT_SIGN && op_e == OP_ADD && src_a == '0)
      |=> (result[WIDTH-1] == $past(imm[IMM_W-1])));

endmodule

// File: tb/sim_flagless_alu.sv
module sim_flagless_alu;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [4:0]  op = '0;
  logic        imm_sel = 1'b0;
  logic [31:0] src_a = '0;
  logic [31:0] src_b = '0;
  logic [15:0] imm = '0;
  logic [31:0] result;
  logic        result_valid;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  flagless_alu u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .op(op), .imm_sel(imm_sel),
    .src_a(src_a), .src_b(src_b), .imm(imm),
    .result(result), .result_valid(result_valid)
  );

  function automatic logic [31:0] model(input logic [4:0] c, input logic s,
                                        input logic [31:0] a, input logic [31:0] b,
                                        input logic [15:0] i);
    logic [31:0] ob;
    int n;
    if (!s)                                  ob = b;
    else if (c >= 6 && c <= 8)               ob = {i, 16'h0000};
    else if (c <= 1 || (c >= 9 && c <= 12))  ob = {{16{i[15]}}, i};
    else                                     ob = {16'h0000, i};
    n = int'(ob[4:0]);
    case (c)
      5'd0:  model = a + ob;
      5'd1:  model = a - ob;
      5'd2, 5'd6: model = a & ob;
      5'd3, 5'd7: model = a | ob;
      5'd4, 5'd8: model = a ^ ob;
      5'd5:  model = ~(a | ob);
      5'd9:  model = {31'd0, a == ob};
      5'd10: model = {31'd0, a != ob};
      5'd11: model = {31'd0, $signed(a) < $signed(ob)};
      5'd12: model = {31'd0, $signed(a) >= $signed(ob)};
      5'd13: model = {31'd0, a < ob};
      5'd14: model = {31'd0, a >= ob};
      5'd15: model = a << n;
      5'd16: model = a >> n;
      5'd17: model = $signed(a) >>> n;
      5'd18: model = (n == 0) ? a : ((a << n) | (a >> (32 - n)));
      5'd19: model = (n == 0) ? a : ((a >> n) | (a << (32 - n)));
      default: model = 32'd0;
    endcase
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Drive one operation, then compare against the model and a literal value.
  task automatic run_op(input string req, input logic [4:0] c, input logic s,
                        input logic [31:0] a, input logic [31:0] b,
                        input logic [15:0] i, input logic [31:0] lit);
    @(negedge clk);
    op = c; imm_sel = s; src_a = a; src_b = b; imm = i; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check({req, " valid"}, {31'd0, result_valid}, 32'd1);
    check({req, " model"}, result, model(c, s, a, b, i));
    check({req, " literal"}, result, lit);
  endtask

  task automatic t_reset;
    check("R11 result at reset", result, 32'd0);
    check("R11 valid at reset", {31'd0, result_valid}, 32'd0);
  endtask

  task automatic t_arith;
    run_op("R1 add wrap", 5'd0, 0, 32'hFFFF_FFFF, 32'd1, 16'h0, 32'd0);
    run_op("R1 add signed overflow", 5'd0, 0, 32'h7FFF_FFFF, 32'd1, 16'h0, 32'h8000_0000);
    run_op("R1 sub negative", 5'd1, 0, 32'd5, 32'd7, 16'h0, 32'hFFFF_FFFE);
    run_op("R2 add neg imm", 5'd0, 1, 32'd10, 32'h0, 16'hFFFF, 32'd9);
    run_op("R2 sub neg imm", 5'd1, 1, 32'd10, 32'h0, 16'h8000, 32'h0000_800A);
  endtask

  task automatic t_logic;
    run_op("R4 and", 5'd2, 0, 32'hF0F0_1234, 32'h0FF0_FF00, 16'h0, 32'h00F0_1200);
    run_op("R4 or", 5'd3, 0, 32'hF000_0001, 32'h0000_0F00, 16'h0, 32'hF000_0F01);
    run_op("R4 xor", 5'd4, 0, 32'hAAAA_5555, 32'hFFFF_0000, 16'h0, 32'h5555_5555);
    run_op("R4 nor", 5'd5, 0, 32'h0000_00FF, 32'hFF00_0000, 16'h0, 32'h00FF_FF00);
    run_op("R2 and zero-ext imm", 5'd2, 1, 32'hFFFF_FFFF, 32'h0, 16'h8001, 32'h0000_8001);
    run_op("R2 nor zero-ext imm", 5'd5, 1, 32'h0, 32'h0, 16'hFFFF, 32'hFFFF_0000);
  endtask

  task automatic t_high;
    run_op("R3 andh", 5'd6, 1, 32'hFFFF_FFFF, 32'h0, 16'h8001, 32'h8001_0000);
    run_op("R3 orh", 5'd7, 1, 32'h0000_1234, 32'h0, 16'hABCD, 32'hABCD_1234);
    run_op("R3 xorh", 5'd8, 1, 32'hFFFF_5A5A, 32'h0, 16'h00FF, 32'hFF00_5A5A);
  endtask

  task automatic t_cmp;
    run_op("R5 eq true", 5'd9, 0, 32'h1234, 32'h1234, 16'h0, 32'd1);
    run_op("R5 ne false", 5'd10, 0, 32'h1234, 32'h1234, 16'h0, 32'd0);
    run_op("R5 lt signed", 5'd11, 0, 32'hFFFF_FFFF, 32'd1, 16'h0, 32'd1);
    run_op("R5 ge signed", 5'd12, 0, 32'hFFFF_FFFF, 32'd1, 16'h0, 32'd0);
    run_op("R5 lt unsigned", 5'd13, 0, 32'hFFFF_FFFF, 32'd1, 16'h0, 32'd0);
    run_op("R5 ge unsigned", 5'd14, 0, 32'hFFFF_FFFF, 32'd1, 16'h0, 32'd1);
    run_op("R2 lt signed imm", 5'd11, 1, 32'hFFFF_0000, 32'h0, 16'h8000, 32'd1);
    run_op("R2 lt unsigned imm", 5'd13, 1, 32'hFFFF_0000, 32'h0, 16'h8000, 32'd0);
    run_op("R2 eq sign-ext imm", 5'd9, 1, 32'hFFFF_FFFE, 32'h0, 16'hFFFE, 32'd1);
  endtask

  task automatic t_shift;
    run_op("R7 sll", 5'd15, 0, 32'h8000_0001, 32'd4, 16'h0, 32'h0000_0010);
    run_op("R7 srl", 5'd16, 0, 32'h8000_0000, 32'd31, 16'h0, 32'h0000_0001);
    run_op("R7 sra", 5'd17, 0, 32'h8000_0000, 32'd31, 16'h0, 32'hFFFF_FFFF);
    run_op("R7 sra positive", 5'd17, 0, 32'h4000_0000, 32'd30, 16'h0, 32'h0000_0001);
    run_op("R6 upper amount ignored", 5'd16, 0, 32'hF000_0000, 32'hFFFF_FFE4, 16'h0, 32'h0F00_0000);
    run_op("R6 imm amount low bits", 5'd15, 1, 32'h1, 32'h0, 16'h0023, 32'h0000_0008);
    run_op("R9 sll zero", 5'd15, 0, 32'hDEAD_BEEF, 32'h20, 16'h0, 32'hDEAD_BEEF);
    run_op("R9 sra zero", 5'd17, 0, 32'h8765_4321, 32'h0, 16'h0, 32'h8765_4321);
  endtask

  task automatic t_rot;
    run_op("R8 rol reg", 5'd18, 0, 32'h8000_0001, 32'd1, 16'h0, 32'h0000_0003);
    run_op("R8 ror reg", 5'd19, 0, 32'h0000_0001, 32'd1, 16'h0, 32'h8000_0000);
    run_op("R8 rol imm", 5'd18, 1, 32'h1234_5678, 32'h0, 16'h0010, 32'h5678_1234);
    run_op("R8 ror 31", 5'd19, 0, 32'h0000_0003, 32'd31, 16'h0, 32'h0000_0006);
    run_op("R9 rol zero", 5'd18, 0, 32'hCAFE_F00D, 32'h40, 16'h0, 32'hCAFE_F00D);
  endtask

  task automatic t_unused;
    run_op("R12 code 20", 5'd20, 0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 16'h0, 32'd0);
    run_op("R12 code 31", 5'd31, 1, 32'h1234, 32'h1, 16'hFFFF, 32'd0);
  endtask

  task automatic t_timing;
    run_op("R10 setup", 5'd0, 0, 32'd100, 32'd23, 16'h0, 32'd123);
    op = 5'd3; src_a = 32'hFFFF_FFFF;
    @(negedge clk);
    check("R10 valid drops", {31'd0, result_valid}, 32'd0);
    check("R10 result held", result, 32'd123);
    @(negedge clk);
    check("R10 still held", result, 32'd123);
    @(negedge clk);
    op = 5'd0; imm_sel = 0; src_a = 32'd1; src_b = 32'd1; start = 1'b1;
    @(negedge clk);
    check("R10 back-to-back first", result, 32'd2);
    src_b = 32'd5;
    @(negedge clk);
    start = 1'b0;
    check("R10 back-to-back valid", {31'd0, result_valid}, 32'd1);
    check("R10 back-to-back second", result, 32'd6);
    @(negedge clk);
    check("R10 valid one cycle", {31'd0, result_valid}, 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_arith();
    t_logic();
    t_high();
    t_cmp();
    t_shift();
    t_rot();
    t_unused();
    t_timing();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog R10 actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule